// File: doc/BRIEF.md
# AES Round-Key Stream Generator

This block expands an AES cipher key into the round keys a round datapath uses, and presents them one 128-bit key per clock cycle. A single load strobe captures the key and its size code. From the next cycle on, the output carries round key 0, then round key 1, and so on with no gap, until the last round key for the chosen size has been shown. A one-cycle completion flag then marks the end of the stream.

The six-word (192-bit) key size is the awkward case. The expansion step produces six 32-bit words at a time, while the consumer takes four. The block therefore keeps a carry register of up to 128 bits and a three-state phase counter. Over every three output cycles it performs two expansion steps and one hold cycle, and splices carried words with fresh ones into the 128-bit output. The 128-bit and 256-bit sizes map expansion words directly onto output words. The 256-bit size takes one step every second cycle.

Top module: `aes_rkey_stream`

## Requirements
- R1: The size code `ksize_i` selects 128-bit keys (2'b00), 192-bit keys (2'b01) or 256-bit keys (2'b10), giving a stream of 11, 13 or 15 round keys. Code 2'b11 behaves as 128-bit.
- R2: In the cycle after a load, `rk_valid_o` is high and `rk_o` equals `key_i[255:128]` as sampled with the load.
- R3: Once started, `rk_valid_o` stays high for exactly as many consecutive cycles as the stream has round keys. Each cycle shows the next round key.
- R4: For 128-bit keys, round key i holds expanded words 4i..4i+3 of the standard AES schedule (RotWord, SubWord, round constant once per four words). Word 0 is in bits [127:96] of the output.
- R5: For 192-bit keys (`key_i[255:64]`, word 0 in the top bits), round key 1 equals `key_i[127:64]` followed by the first two words of the first six-word expansion chunk. The remaining keys follow the standard schedule on a repeating three-cycle repacking pattern.
- R6: For 256-bit keys, round key 1 equals `key_i[127:0]`. Later keys follow the standard schedule, including the extra SubWord in the middle of each eight-word step.
- R7: `rk_valid_o` drops in the cycle after the last round key. `done_o` is high for that one cycle only.
- R8: A load while a stream is running abandons it at once. The new stream starts in the next cycle, and no `done_o` is raised for the abandoned stream.
- R9: While reset is held and after its release with no load, `rk_valid_o` and `done_o` are low.
- R10: Key bits beyond the selected size have no effect: `key_i[63:0]` for 192-bit keys and `key_i[127:0]` for 128-bit keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture key and size, start a stream |
| ksize_i | input | 2 | Key size code |
| key_i | input | 256 | Cipher key, most significant word first |
| rk_o | output | 128 | Current round key |
| rk_valid_o | output | 1 | `rk_o` holds a round key |
| done_o | output | 1 | One-cycle end-of-stream flag |

## Verification
Round key k of a stream is due k+1 cycles after the edge that samples the load. `done_o` is due one cycle after the last key, for N+1 cycles after the load edge with N keys. The driver applies the load on a falling edge and pushes the software-expanded keys into a queue. A monitor samples on each later falling edge, popping one entry whenever the valid flag is up, so each comparison falls in the half cycle when the key under test is stable. The driver separately counts falling edges to confirm that valid holds for exactly N samples and that the completion flag sits at sample N+1 and is gone at N+2.

// File: rtl/aes_rks_pkg.sv
package aes_rks_pkg;

   typedef enum logic [1:0] {
      KS_128 = 2'b00,
      KS_192 = 2'b01,
      KS_256 = 2'b10
   } ksize_e;

   typedef enum logic [1:0] {
      PH_0 = 2'd0,
      PH_1 = 2'd1,
      PH_2 = 2'd2
   } phase_e;

   function automatic ksize_e ks_decode(input logic [1:0] code);
      case (code)
         2'b01:   return KS_192;
         2'b10:   return KS_256;
         default: return KS_128;
      endcase
   endfunction

   function automatic int rk_count(input ksize_e ks);
      case (ks)
         KS_192:  return 13;
         KS_256:  return 15;
         default: return 11;
      endcase
   endfunction

   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] x;
      acc = 8'h00;
      x   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ x;
         x = gf_xtime(x);
      end
      return acc;
   endfunction

endpackage

// File: rtl/aes_rks_sbox.sv
module aes_rks_sbox
   import aes_rks_pkg::*;
(
   input  logic [7:0] a_i,
   output logic [7:0] s_o
);

   logic [7:0] inv;
   logic [7:0] pw;

   // a^254 is the multiplicative inverse (and maps 0 to 0)
   always_comb begin
      pw  = a_i;
      inv = 8'h01;
      for (int i = 1; i < 8; i++) begin
         pw  = gf_mul(pw, pw);
         inv = gf_mul(inv, pw);
      end
      s_o = inv
          ^ {inv[6:0], inv[7]}
          ^ {inv[5:0], inv[7:6]}
          ^ {inv[4:0], inv[7:5]}
          ^ {inv[3:0], inv[7:4]}
          ^ 8'h63;
   end

endmodule

// File: rtl/aes_rks_subword.sv
module aes_rks_subword #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] w_i,
   output logic [WORD_W-1:0] s_o
);

   localparam int NBYTE = WORD_W / 8;

   for (genvar g = 0; g < NBYTE; g++) begin : g_byte
      aes_rks_sbox u_sb (
         .a_i (w_i[8*g +: 8]),
         .s_o (s_o[8*g +: 8])
      );
   end

endmodule

// File: rtl/aes_rks_step.sv
module aes_rks_step
   import aes_rks_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NWORD  = 8
) (
   input  logic [NWORD*WORD_W-1:0] chunk_i,
   input  ksize_e                  ks_i,
   input  logic [7:0]              rcon_i,
   output logic [NWORD*WORD_W-1:0] nxt_o
);

   localparam int HALF = NWORD / 2;

   logic [0:NWORD-1][WORD_W-1:0] w;
   logic [0:HALF-1][WORD_W-1:0]  n_lo;
   logic [0:HALF-1][WORD_W-1:0]  n_hi;
   logic [WORD_W-1:0]            core_in;
   logic [WORD_W-1:0]            core_sub;
   logic [WORD_W-1:0]            mid_sub;

   assign w = chunk_i;

   always_comb begin
      case (ks_i)
         KS_192:  core_in = w[5];
         KS_256:  core_in = w[7];
         default: core_in = w[3];
      endcase
   end

   aes_rks_subword #(.WORD_W(WORD_W)) u_core (
      .w_i ({core_in[WORD_W-9:0], core_in[WORD_W-1 -: 8]}),
      .s_o (core_sub)
   );

   always_comb begin
      n_lo[0] = w[0] ^ core_sub ^ {rcon_i, {(WORD_W-8){1'b0}}};
      for (int i = 1; i < HALF; i++) n_lo[i] = w[i] ^ n_lo[i-1];
   end

   aes_rks_subword #(.WORD_W(WORD_W)) u_mid (
      .w_i (n_lo[HALF-1]),
      .s_o (mid_sub)
   );

   always_comb begin
      n_hi = '0;
      case (ks_i)
         KS_192: begin
            n_hi[0] = w[HALF]   ^ n_lo[HALF-1];
            n_hi[1] = w[HALF+1] ^ n_hi[0];
         end
         KS_256: begin
            n_hi[0] = w[HALF] ^ mid_sub;
            for (int i = 1; i < HALF; i++) n_hi[i] = w[HALF+i] ^ n_hi[i-1];
         end
         default: n_hi = '0;
      endcase
   end

   assign nxt_o = {n_lo, n_hi};

endmodule

// File: rtl/aes_rkey_stream.sv
module aes_rkey_stream
   import aes_rks_pkg::*;
#(
   parameter int KEY_W  = 256,
   parameter int RK_W   = 128,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [1:0]       ksize_i,
   input  logic [KEY_W-1:0] key_i,
   output logic [RK_W-1:0]  rk_o,
   output logic             rk_valid_o,
   output logic             done_o
);

   localparam int NWORD  = KEY_W / WORD_W;
   localparam int HALF_W = RK_W / 2;
   localparam int MAXRK  = 15;

   if (KEY_W != 2 * RK_W || RK_W != 4 * WORD_W || WORD_W != 32) begin : g_bad_width
      $error("aes_rkey_stream: widths must be 256/128/32");
   end
   if ((1 << CNT_W) <= MAXRK) begin : g_bad_cnt
      $error("aes_rkey_stream: CNT_W too small for 15 round keys");
   end

   ksize_e            mode_q, mode_d;
   phase_e            phase_q, phase_d;
   logic [KEY_W-1:0]  chunk_q, chunk_d, nxt;
   logic [RK_W-1:0]   carry_q, carry_d;
   logic [RK_W-1:0]   rk_q, rk_d;
   logic [7:0]        rcon_q, rcon_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              valid_q, valid_d;
   logic              done_q, done_d;
   logic              last;

   aes_rks_step #(.WORD_W(WORD_W), .NWORD(NWORD)) u_step (
      .chunk_i (chunk_q),
      .ks_i    (mode_q),
      .rcon_i  (rcon_q),
      .nxt_o   (nxt)
   );

   assign last = (cnt_q == CNT_W'(rk_count(mode_q)));

   always_comb begin
      mode_d  = mode_q;
      phase_d = phase_q;
      chunk_d = chunk_q;
      carry_d = carry_q;
      rk_d    = rk_q;
      rcon_d  = rcon_q;
      cnt_d   = cnt_q;
      valid_d = valid_q;
      done_d  = 1'b0;
      if (load_i) begin
         mode_d  = ks_decode(ksize_i);
         chunk_d = key_i;
         rk_d    = key_i[KEY_W-1 -: RK_W];
         carry_d = key_i[RK_W-1:0];
         phase_d = PH_1;
         rcon_d  = 8'h01;
         cnt_d   = CNT_W'(1);
         valid_d = 1'b1;
      end else if (valid_q) begin
         if (last) begin
            valid_d = 1'b0;
            done_d  = 1'b1;
         end else begin
            cnt_d = cnt_q + CNT_W'(1);
            case (mode_q)
               KS_192: begin
                  case (phase_q)
                     PH_1: begin
                        chunk_d = nxt;
                        rk_d    = {carry_q[RK_W-1 -: HALF_W], nxt[KEY_W-1 -: HALF_W]};
                        carry_d = nxt[KEY_W-HALF_W-1 -: RK_W];
                        rcon_d  = gf_xtime(rcon_q);
                        phase_d = PH_2;
                     end
                     PH_2: begin
                        rk_d    = carry_q;
                        phase_d = PH_0;
                     end
                     default: begin
                        chunk_d = nxt;
                        rk_d    = nxt[KEY_W-1 -: RK_W];
                        carry_d = {nxt[RK_W-1 -: HALF_W], {HALF_W{1'b0}}};
                        rcon_d  = gf_xtime(rcon_q);
                        phase_d = PH_1;
                     end
                  endcase
               end
               KS_256: begin
                  if (phase_q == PH_1) begin
                     rk_d    = carry_q;
                     phase_d = PH_0;
                  end else begin
                     chunk_d = nxt;
                     rk_d    = nxt[KEY_W-1 -: RK_W];
                     carry_d = nxt[RK_W-1:0];
                     rcon_d  = gf_xtime(rcon_q);
                     phase_d = PH_1;
                  end
               end
               default: begin
                  chunk_d = nxt;
                  rk_d    = nxt[KEY_W-1 -: RK_W];
                  rcon_d  = gf_xtime(rcon_q);
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= KS_128;
         phase_q <= PH_0;
         chunk_q <= '0;
         carry_q <= '0;
         rk_q    <= '0;
         rcon_q  <= 8'h01;
         cnt_q   <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         phase_q <= phase_d;
         chunk_q <= chunk_d;
         carry_q <= carry_d;
         rk_q    <= rk_d;
         rcon_q  <= rcon_d;
         cnt_q   <= cnt_d;
         valid_q <= valid_d;
         done_q  <= done_d;
      end
   end

   assign rk_o       = rk_q;
   assign rk_valid_o = valid_q;
   assign done_o     = done_q;

endmodule

// File: rtl/aes_rkey_stream_chk.sv
module aes_rkey_stream_chk #(
   parameter int RK_W = 128
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load_i,
   input logic [1:0]      ksize_i,
   input logic [RK_W-1:0] key_hi_i,
   input logic [RK_W-1:0] rk_o,
   input logic            rk_valid_o,
   input logic            done_o
);

   logic [4:0] run_cnt;
   logic [4:0] exp_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         exp_n   <= 5'd11;
      end else if (load_i) begin
         run_cnt <= '0;
         case (ksize_i)
            2'b01:   exp_n <= 5'd13;
            2'b10:   exp_n <= 5'd15;
            default: exp_n <= 5'd11;
         endcase
      end else if (rk_valid_o) begin
         run_cnt <= run_cnt + 5'd1;
      end
   end

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> run_cnt == exp_n);                                   // R1
   AST_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (rk_valid_o && rk_o == $past(key_hi_i)));            // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                            // R7
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!rk_valid_o && $past(rk_valid_o)));                 // R7
   AST_NO_DONE_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !done_o);                                            // R8
   AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_valid_o && !load_i && run_cnt + 5'd1 < exp_n) |=> rk_valid_o); // R3

endmodule

bind aes_rkey_stream aes_rkey_stream_chk #(.RK_W(RK_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .ksize_i    (ksize_i),
   .key_hi_i   (key_i[KEY_W-1 -: RK_W]),
   .rk_o       (rk_o),
   .rk_valid_o (rk_valid_o),
   .done_o     (done_o)
);

// File: tb/sim_aes_rkey_stream.sv
`timescale 1ns/1ps
module sim_aes_rkey_stream;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [1:0]   ksize_i = 2'b00;
   logic [255:0] key_i = '0;
   logic [127:0] rk_o;
   logic         rk_valid_o;
   logic         done_o;

   int total = 0;
   int bad = 0;
   logic [127:0] exp_q[$];
   string        tag_q[$];
   logic [127:0] last_rk = '0;

   always #10 clk = ~clk;

   aes_rkey_stream u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .ksize_i    (ksize_i),
      .key_i      (key_i),
      .rk_o       (rk_o),
      .rk_valid_o (rk_valid_o),
      .done_o     (done_o)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, expv);
      end
   endtask

   // ---- software model of the AES key schedule ----
   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] m_sbox(input logic [7:0] a);
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int x = 1; x < 256; x++) if (m_mul(a, 8'(x)) == 8'h01) inv = 8'(x);
      s = 8'h63;
      for (int i = 0; i < 8; i++)
         s[i] = s[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      return s;
   endfunction

   function automatic logic [31:0] m_subw(input logic [31:0] w);
      return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
   endfunction

   // pushes up to lim round keys; returns the full count
   function automatic int push_expected(input logic [1:0] ks, input logic [255:0] key,
                                        input int lim, input string tag);
      logic [31:0] w [0:59];
      logic [31:0] t;
      logic [7:0]  rc = 8'h01;
      int nk = (ks == 2'b01) ? 6 : (ks == 2'b10) ? 8 : 4;
      int n  = nk + 7;
      for (int i = 0; i < nk; i++) w[i] = key[255 - 32*i -: 32];
      for (int i = nk; i < 4*n; i++) begin
         t = w[i-1];
         if (i % nk == 0) begin
            t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = m_mul(rc, 8'h02);
         end else if (nk == 8 && i % 8 == 4) begin
            t = m_subw(t);
         end
         w[i] = w[i-nk] ^ t;
      end
      for (int r = 0; r < n && r < lim; r++) begin
         exp_q.push_back({w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]});
         tag_q.push_back(r == 0 ? "R2" : tag);
      end
      return n;
   endfunction

   // ---- monitor: pops one expected key per valid sample ----
   always @(negedge clk) begin
      if (rst_n) begin
         if (rk_valid_o) begin
            if (exp_q.size() == 0) begin
               chk("R3 extra key", rk_o, '0);
            end else begin
               chk(tag_q.pop_front(), rk_o, exp_q.pop_front());
               last_rk = rk_o;
            end
         end
         if (done_o && exp_q.size() != 0) chk("R8 early done", 128'(exp_q.size()), 128'd0);
      end
   end

   task automatic tail(input int n);
      chk("R3 valid", 128'(rk_valid_o), 128'd1);
      for (int k = 1; k < n; k++) begin
         @(negedge clk);
         chk("R3 valid", 128'(rk_valid_o), 128'd1);
      end
      @(negedge clk);
      chk("R7 done high", 128'(done_o), 128'd1);
      chk("R7 valid low", 128'(rk_valid_o), 128'd0);
      @(negedge clk);
      chk("R7 done pulse", 128'(done_o), 128'd0);
      chk("R1 count", 128'(exp_q.size()), 128'd0);
   endtask

   task automatic run(input logic [1:0] ks, input logic [255:0] key, input string tag);
      int n;
      n = push_expected(ks, key, 99, tag);
      @(negedge clk);
      load_i = 1'b1; ksize_i = ks; key_i = key;
      @(negedge clk);
      load_i = 1'b0; key_i = ~key;
      tail(n);
   endtask

   task automatic run_restart(input logic [1:0] ksa, input logic [255:0] ka,
                              input logic [1:0] ksb, input logic [255:0] kb);
      int n;
      n = push_expected(ksa, ka, 3, "R8");
      n = push_expected(ksb, kb, 99, "R8");
      @(negedge clk);
      load_i = 1'b1; ksize_i = ksa; key_i = ka;
      @(negedge clk);
      load_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8 no done", 128'(done_o), 128'd0);
      load_i = 1'b1; ksize_i = ksb; key_i = kb;
      @(negedge clk);
      load_i = 1'b0;
      tail(n);
   endtask

   initial begin
      #(20 * 150000);
      chk("watchdog", 128'd1, 128'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset valid", 128'(rk_valid_o), 128'd0);
      chk("R9 reset done", 128'(done_o), 128'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 idle valid", 128'(rk_valid_o), 128'd0);
      chk("R9 idle done", 128'(done_o), 128'd0);

      run(2'b00, {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, "R4");
      chk("R4 known last key", last_rk, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
      run(2'b01, {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, "R5");
      run(2'b01, {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, "R5");
      run(2'b10, 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, "R6");
      run(2'b10, 256'hffffffffffffffffffffffffffffffff00000000000000000000000000000000, "R6");
      run(2'b11, {128'h000102030405060708090a0b0c0d0e0f, 128'h0}, "R1");
      run(2'b01, {192'hfedcba98765432100123456789abcdef0f1e2d3c4b5a6978, 64'hdeadbeefcafef00d}, "R10");
      run(2'b00, {128'h00112233445566778899aabbccddeeff, 128'h5555aaaa3333cccc0f0f0f0ff0f0f0f0}, "R10");
      run_restart(2'b10, 256'h0123456789abcdeffedcba98765432100011223344556677_8899aabbccddeeff,
                  2'b01, {192'h1111111122222222333333334444444455555555_66666666, 64'h0});
      run_restart(2'b00, {128'hcafebabe0badf00d1234567887654321, 128'h0},
                  2'b10, 256'h1f1e1d1c1b1a191817161514131211100f0e0d0c0b0a09080706050403020100);
      repeat (4) @(negedge clk);
      chk("R7 idle after run", 128'(rk_valid_o), 128'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule